// File: doc/BRIEF.md
# Ring Secondary Station Repeater

This block is the line-side core of a secondary station on a serial ring network. While the station is out of the ring, it passes every received line bit straight to the outgoing line. While it is part of the ring, it sends every received bit back out exactly one bit period later. When it has a message to send and is allowed to, it turns an incoming end-of-poll pattern into an opening flag, sends its message, and closes the message with a new end-of-poll.

End-of-poll is a 0 followed by seven 1s, in line order. The station enters the ring only at an end-of-poll, and it also leaves the ring only at an end-of-poll. The end-of-poll that brings the station into the ring only switches in the one-bit delay. The first end-of-poll that the station may convert is a later one.

The message arrives as a serial stream that is already bit-stuffed. It is offered with a valid/last handshake, and the block pulls one bit per bit period. Bit timing comes from a one-cycle bit-rate enable, `bit_en`. Every line bit and message bit is sampled on a clock edge where `bit_en` is high.

Top module: `lp_loop_repeater`

## Requirements
- R1: While `cfg_loop` is low, `tx_bit` equals `rx_bit` in the same cycle, and `on_loop` and `loop_sending` stay low.
- R2: With `cfg_loop` high and the station not yet on the ring, `tx_bit` follows `rx_bit` with no delay. An end-of-poll is a received 0 followed by seven received 1s. When the seventh 1 is sampled while `cfg_go_off` is low, `on_loop` rises.
- R3: While on the ring and not sending, the `tx_bit` driven during each bit period equals the `rx_bit` sampled in the bit period before it.
- R4: The end-of-poll that brings the station onto the ring is repeated unchanged, even when `cfg_go_active` and `msg_valid` are high. `loop_sending` stays low for that end-of-poll.
- R5: While on the ring and not sending, an end-of-poll received with `cfg_go_active` and `msg_valid` high (and `cfg_go_off` low) has its seventh 1 sent as 0, and `loop_sending` rises.
- R6: In the bit period after the flipped bit, `msg_ready` is high with `bit_en`. Each accepted message bit goes out one bit period after it is accepted, in order. `rx_bit` has no effect on `tx_bit` while sending.
- R7: After the message bit that carries `msg_last`, the line carries a 0 followed by seven 1s. The station then resumes repeating with the one-bit delay.
- R8: `loop_sending` is high from the flipped bit through the last 1 of the closing end-of-poll. It is low in the bit period after that, and it is never high while `on_loop` is low.
- R9: While on the ring with `cfg_go_off` high, the delay stays in place until the next end-of-poll. After that end-of-poll, `tx_bit` follows `rx_bit` with no delay and `on_loop` is low. While `cfg_go_off` stays high, further end-of-polls do not bring the station back.
- R10: Clearing `cfg_loop` makes `tx_bit` equal `rx_bit` in the same cycle. `on_loop` and `loop_sending` are low after the next clock edge.
- R11: After reset, `on_loop`, `loop_sending` and `msg_ready` are low.
- R12: An end-of-poll received on the ring while `cfg_go_active` is low is repeated unchanged with the one-bit delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle bit-period strobe |
| rx_bit | input | 1 | Received line bit |
| cfg_loop | input | 1 | Enables ring operation |
| cfg_go_active | input | 1 | Permits sending at the next usable end-of-poll |
| cfg_go_off | input | 1 | Requests leaving the ring at the next end-of-poll |
| msg_valid | input | 1 | Message bit is offered |
| msg_bit | input | 1 | Pre-stuffed message bit |
| msg_last | input | 1 | Marks the final message bit |
| msg_ready | output | 1 | Message bit taken this cycle |
| tx_bit | output | 1 | Transmitted line bit |
| on_loop | output | 1 | One-bit delay is in the path |
| loop_sending | output | 1 | Station owns the line |

## Verification
A stale or wrong state shows at the ports as a wrong line delay, and it shows within the same bit period. In that period `tx_bit` either follows `rx_bit` directly or carries the previous bit when it should not. A miscounted end-of-poll shows either as a missing 0 in place of the seventh 1, or as a 0 where a repeated 1 belongs. A bad closing sequence shows up to eight bit periods after the last message bit, as a wrong bit in the closing 0-then-seven-1s tail or as `loop_sending` dropping at the wrong period.

// File: rtl/lp_pkg.sv
package lp_pkg;

    // Length of the end-of-poll pattern on the line: one 0 and then EOP_W-1 ones.
    localparam int EOP_W = 8;

    typedef enum logic [2:0] {
        ST_OFF,    // ring operation disabled
        ST_HUNT,   // pass-through, waiting for an end-of-poll to enter
        ST_ECHO,   // on the ring, repeating with one bit of delay
        ST_MSG,    // sending message bits
        ST_TAIL    // sending the closing end-of-poll
    } loop_st_t;

    typedef struct packed {
        logic line;     // registered line bit used in delayed mode
        logic on;       // delay is in the path
        logic sending;  // station owns the line
        logic ready;    // message bit taken this cycle
    } loop_out_t;

    function automatic logic st_on_loop(input loop_st_t st);
        return (st == ST_ECHO) || (st == ST_MSG) || (st == ST_TAIL);
    endfunction

endpackage

// File: rtl/lp_eop_detect.sv
module lp_eop_detect #(
    parameter int W = lp_pkg::EOP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx_bit,
    output logic eop
);
    localparam logic [W-1:0] PAT = {1'b0, {(W-1){1'b1}}};

    logic [W-2:0] hist;

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '1;
        else if (tick)
            hist <= {hist[W-3:0], rx_bit};
    end

    // Match is flagged while the final 1 is being sampled, before it is stored.
    assign eop = tick && ({hist, rx_bit} == PAT);

endmodule

// File: rtl/lp_tail_gen.sv
module lp_tail_gen #(
    parameter int W = lp_pkg::EOP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    output logic tail_bit,
    output logic tail_done
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else if (tick && cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign tail_bit  = (cnt != '0);
    assign tail_done = (cnt == LAST);

endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
    import lp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx_bit,
    input  logic      eop,
    input  logic      cfg_loop,
    input  logic      cfg_go_active,
    input  logic      cfg_go_off,
    input  logic      msg_valid,
    input  logic      msg_bit,
    input  logic      msg_last,
    input  logic      tail_bit,
    input  logic      tail_done,
    output loop_st_t  st,
    output loop_out_t o
);
    logic line_q;
    logic send_q;

    always_ff @(posedge clk) begin
        if (rst || !cfg_loop) begin
            st     <= ST_OFF;
            line_q <= 1'b1;
            send_q <= 1'b0;
        end else if (st == ST_OFF) begin
            st <= ST_HUNT;
        end else if (tick) begin
            unique case (st)
                ST_HUNT: begin
                    line_q <= rx_bit;
                    if (eop && !cfg_go_off)
                        st <= ST_ECHO;
                end
                ST_ECHO: begin
                    send_q <= 1'b0;
                    if (eop && cfg_go_off) begin
                        line_q <= rx_bit;
                        st     <= ST_HUNT;
                    end else if (eop && cfg_go_active && msg_valid) begin
                        line_q <= 1'b0;
                        send_q <= 1'b1;
                        st     <= ST_MSG;
                    end else begin
                        line_q <= rx_bit;
                    end
                end
                ST_MSG: begin
                    if (msg_valid) begin
                        line_q <= msg_bit;
                        if (msg_last)
                            st <= ST_TAIL;
                    end else begin
                        line_q <= 1'b1;
                    end
                end
                ST_TAIL: begin
                    line_q <= tail_bit;
                    if (tail_done)
                        st <= ST_ECHO;
                end
                default: st <= ST_OFF;
            endcase
        end
    end

    always_comb begin
        o.line    = line_q;
        o.on      = st_on_loop(st);
        o.sending = send_q;
        o.ready   = cfg_loop && tick && (st == ST_MSG);
    end

endmodule

// File: rtl/lp_loop_repeater.sv
module lp_loop_repeater
    import lp_pkg::*;
#(
    parameter int EOP_LEN = lp_pkg::EOP_W
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic cfg_loop,
    input  logic cfg_go_active,
    input  logic cfg_go_off,
    input  logic msg_valid,
    input  logic msg_bit,
    input  logic msg_last,
    output logic msg_ready,
    output logic tx_bit,
    output logic on_loop,
    output logic loop_sending
);
    logic      eop;
    logic      tail_bit;
    logic      tail_done;
    loop_st_t  st;
    loop_out_t ctl;

    lp_eop_detect #(.W(EOP_LEN)) u_det (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_en),
        .rx_bit (rx_bit),
        .eop    (eop)
    );

    lp_tail_gen #(.W(EOP_LEN)) u_tail (
        .clk       (clk),
        .rst       (rst),
        .active    (st == ST_TAIL),
        .tick      (bit_en),
        .tail_bit  (tail_bit),
        .tail_done (tail_done)
    );

    lp_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tick          (bit_en),
        .rx_bit        (rx_bit),
        .eop           (eop),
        .cfg_loop      (cfg_loop),
        .cfg_go_active (cfg_go_active),
        .cfg_go_off    (cfg_go_off),
        .msg_valid     (msg_valid),
        .msg_bit       (msg_bit),
        .msg_last      (msg_last),
        .tail_bit      (tail_bit),
        .tail_done     (tail_done),
        .st            (st),
        .o             (ctl)
    );

    assign tx_bit       = (cfg_loop && ctl.on) ? ctl.line : rx_bit;
    assign on_loop      = ctl.on;
    assign loop_sending = ctl.sending;
    assign msg_ready    = ctl.ready;

endmodule

// File: rtl/lp_loop_chk.sv
module lp_loop_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic rx_bit,
    input logic cfg_loop,
    input logic msg_ready,
    input logic tx_bit,
    input logic on_loop,
    input logic loop_sending
);
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !cfg_loop |=> (!on_loop && !loop_sending)); // R10

    AST_SEND_NEEDS_LOOP: assert property (@(posedge clk) disable iff (rst)
        loop_sending |-> on_loop); // R8

    AST_READY_IN_SEND: assert property (@(posedge clk) disable iff (rst)
        msg_ready |-> (loop_sending && bit_en)); // R6

    AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($rose(loop_sending) && cfg_loop) |-> !tx_bit); // R5

    AST_ZERO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (bit_en && cfg_loop && on_loop && !loop_sending && !rx_bit)
        |=> (!cfg_loop || !tx_bit)); // R3

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (on_loop && cfg_loop && $past(on_loop && cfg_loop && !bit_en))
        |-> $stable(tx_bit)); // R3

endmodule

bind lp_loop_repeater lp_loop_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .rx_bit       (rx_bit),
    .cfg_loop     (cfg_loop),
    .msg_ready    (msg_ready),
    .tx_bit       (tx_bit),
    .on_loop      (on_loop),
    .loop_sending (loop_sending)
);

// File: tb/sim_lp_loop_repeater.sv
module sim_lp_loop_repeater;
    logic clk = 1'b0;
    logic rst, bit_en, rx_bit, cfg_loop, cfg_go_active, cfg_go_off;
    logic msg_valid, msg_bit, msg_last;
    logic msg_ready, tx_bit, on_loop, loop_sending;

    int total = 0;
    int bad   = 0;
    logic s_tx, s_on, s_snd, s_rdy;

    always #2 clk = ~clk;

    lp_loop_repeater u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
        .cfg_loop(cfg_loop), .cfg_go_active(cfg_go_active), .cfg_go_off(cfg_go_off),
        .msg_valid(msg_valid), .msg_bit(msg_bit), .msg_last(msg_last),
        .msg_ready(msg_ready), .tx_bit(tx_bit), .on_loop(on_loop),
        .loop_sending(loop_sending)
    );

    // Line stimulus (MSB first); expected output is each bit one period later.
    localparam int NV = 4;
    localparam logic [15:0] VEC [NV] = '{16'hA5C3, 16'h00FF, 16'h3C96, 16'h80FE};
    localparam logic [4:0] MSG = 5'b01101; // sent from bit 0 upward: 1,0,1,1,0

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One bit period: drive inputs with bit_en, sample outputs before the edge.
    task automatic step(input logic b, input logic mv, input logic mb, input logic ml);
        @(negedge clk);
        rx_bit = b; msg_valid = mv; msg_bit = mb; msg_last = ml; bit_en = 1'b1;
        #1;
        s_tx = tx_bit; s_on = on_loop; s_snd = loop_sending; s_rdy = msg_ready;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic prev;
        rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b1; cfg_loop = 1'b0;
        cfg_go_active = 1'b0; cfg_go_off = 1'b0;
        msg_valid = 1'b0; msg_bit = 1'b0; msg_last = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 on_loop", on_loop, 1'b0);
        chk("R11 loop_sending", loop_sending, 1'b0);
        chk("R11 msg_ready", msg_ready, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R1: ring disabled, end-of-poll passes through untouched
        for (int i = 0; i < 9; i++) begin
            logic b;
            b = (i == 0) ? 1'b0 : 1'b1;
            step(b, 1'b0, 1'b0, 1'b0);
            chk("R1 tx", s_tx, b);
            chk("R1 on_loop", s_on, 1'b0);
        end

        // R2/R4: enable ring with go-active and a pending message
        @(negedge clk);
        cfg_loop = 1'b1; cfg_go_active = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            logic b;
            b = (i == 2) ? 1'b0 : 1'b1;
            step(b, 1'b1, 1'b0, 1'b0);
            chk("R2 no delay", s_tx, b);
            chk("R2 off loop", s_on, 1'b0);
        end
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 on_loop rise", s_on, 1'b1);
        chk("R4 entry eop unchanged", s_tx, 1'b1);
        chk("R4 no sending", s_snd, 1'b0);
        chk("R4 no ready", s_rdy, 1'b0);
        prev = 1'b0;

        // R3/R12: table of line patterns repeated with one bit of delay
        cfg_go_active = 1'b0;
        for (int v = 0; v < NV; v++) begin
            for (int k = 15; k >= 0; k--) begin
                step(VEC[v][k], 1'b0, 1'b0, 1'b0);
                chk((v == 1) ? "R12 eop echoed" : "R3 delayed echo", s_tx, prev);
                prev = VEC[v][k];
            end
        end

        // R5..R8: convert the next end-of-poll and send the message
        cfg_go_active = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 delayed echo", s_tx, prev);
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            chk("R3 delayed echo", s_tx, (i == 0) ? 1'b0 : 1'b1);
        end
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, MSG[i], (i == 4));
            if (i == 0) begin
                chk("R5 flag bit", s_tx, 1'b0);
                chk("R5 sending rise", s_snd, 1'b1);
                chk("R6 ready", s_rdy, 1'b1);
            end else begin
                chk("R6 message bit", s_tx, MSG[i-1]);
            end
        end
        cfg_go_active = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 last message bit", s_tx, MSG[4]);
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0);
            chk("R7 closing pattern", s_tx, (i == 0) ? 1'b0 : 1'b1);
            chk("R8 sending held", s_snd, 1'b1);
        end
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 echo resumes", s_tx, 1'b0);
        chk("R8 sending cleared", s_snd, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 echo resumes", s_tx, 1'b1);
        prev = 1'b0;

        // R9: leave the ring at the next end-of-poll
        cfg_go_off = 1'b1;
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            chk("R9 delay kept", s_tx, prev);
            chk("R9 still on", s_on, 1'b1);
            prev = 1'b1;
        end
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 no delay", s_tx, 1'b0);
        chk("R9 off loop", s_on, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 stays off", s_on, 1'b0);
        chk("R9 pass", s_tx, 1'b0);

        // R4 again, then R10: drop ring mode
        cfg_go_off = 1'b0; cfg_go_active = 1'b1;
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 reentry unchanged", s_tx, 1'b1);
        chk("R4 reentry no send", s_snd, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 delayed after reentry", s_tx, 1'b0);
        @(negedge clk);
        cfg_loop = 1'b0; rx_bit = 1'b0;
        #1;
        chk("R10 immediate pass", tx_bit, 1'b0);
        @(posedge clk); #1;
        chk("R10 on_loop low", on_loop, 1'b0);
        chk("R10 sending low", loop_sending, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule